// File: doc/BRIEF.md
# I2C Host Message Sequencer

This block turns a message descriptor into the full series of primitive bus events that an I2C host engine needs to carry out one message. It sends one event at a time, waits for the engine's completion strobe, checks the result, and then picks the next event from the descriptor. It covers plain writes, plain reads, and write-then-read messages joined by a repeated start. It handles both 7-bit and 10-bit target addresses. The bit-level SCL/SDA engine sits below this block and is not part of it.

The sequencer state is the six request/status bits it drives towards the engine: five one-hot event requests and one transmit-in-progress flag. When all six bits are zero the sequencer is idle, and only then does it take a new descriptor. A small phase register records which kind of byte is being transmitted. Write data comes in one byte at a time, and the sequencer pulses `wr_next` each time it consumes `wr_data`. Each received byte is handed out with a one-cycle `rx_valid` strobe. When the closing stop completes, the sequencer pulses `done`. If the target refused a byte, `err` is also set.

Top module: `i2c_msg_seq`

## Requirements
- R1: After reset, `ev_req` is 0, `tx_act` is 0, `desc_ready` is 1, and `done`, `err` and `rx_valid` are 0.
- R2: `ev_req` bit positions are: 0 start, 1 repeated start, 2 stop, 3 receive, 4 acknowledge. At most one of `{ev_req, tx_act}` is set at any time, and a request holds steady until `ev_done` is seen.
- R3: A descriptor is taken only when `desc_valid` is high and the block is idle. It always starts with a start event, and the start is followed by a transmission. A `desc_valid` pulse during a message is ignored.
- R4: 7-bit addressing sends `{addr[6:0], rnw}` as the first byte. In a combined message, the byte after the repeated start is `{addr[6:0], 1}`.
- R5: 10-bit addressing sends `{11110, addr[9:8], 0}` and then `addr[7:0]`. If a read follows, a repeated start is issued and then `{11110, addr[9:8], 1}` is sent.
- R6: A write sends `desc_wr_cnt` data bytes in the order `wr_data` presents them, with one `wr_next` pulse for each byte consumed.
- R7: When `desc_rnw` is 0 and `desc_rd_cnt` is greater than 0, a repeated start (not a stop) separates the write phase from the read phase.
- R8: The read phase runs `desc_rd_cnt` receive events. Each receive is followed by an acknowledge event, with `ack_nack` = 0 for every byte except the last, where it is 1. Each byte appears on `rx_data` with a one-cycle `rx_valid`.
- R9: If `ack_in` = 1 when a transmission completes, the next event is a stop, `err` goes to 1, and nothing more is transmitted or received.
- R10: `done` pulses for exactly one cycle after the stop completes. `err` stays valid until the next descriptor is taken, which clears it.
- R11: A write with both counts at 0 produces start, address byte, stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| desc_valid | input | 1 | Descriptor offered |
| desc_ready | output | 1 | Sequencer idle, descriptor can be taken |
| desc_addr | input | 10 | Target address (low 7 bits in 7-bit mode) |
| desc_ten | input | 1 | 1 selects 10-bit addressing |
| desc_rnw | input | 1 | 1 = read-only message |
| desc_wr_cnt | input | CNT_W | Bytes to write |
| desc_rd_cnt | input | CNT_W | Bytes to read |
| wr_data | input | 8 | Current write byte |
| wr_next | output | 1 | Pulse: `wr_data` consumed |
| ev_req | output | 5 | One-hot event request to the engine |
| tx_act | output | 1 | Host byte transmission in progress |
| tx_byte | output | 8 | Byte to transmit |
| ack_nack | output | 1 | Level to send in the acknowledge cycle (1 = NACK) |
| ev_done | input | 1 | Completion strobe from the engine |
| ack_in | input | 1 | Target acknowledge after a transmit (1 = NACK) |
| rx_byte | input | 8 | Byte received by the engine |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | Pulse: `rx_data` updated |
| done | output | 1 | Pulse: message finished |
| err | output | 1 | Message aborted by NACK |

## Verification
The bench logs every event the engine model completes, together with its byte. It compares that log with a sequence built from the descriptor. A design that sent the wrong R/W bit, skipped the low 10-bit address byte, or issued stop instead of repeated start in a combined read shows up as a mismatch in the log. NACK injection is tested on the address byte and on a middle data byte. A design that kept sending after a refusal would log extra transmissions and never flag `err`. The tests also cover a zero-length write, the ACK/NACK level on the last read byte (a design with an off-by-one here would NACK too early), and a descriptor pulse in the middle of a message that must leave the running message unchanged.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;
   localparam int EV_N      = 5;
   localparam int EV_START  = 0;
   localparam int EV_RSTART = 1;
   localparam int EV_STOP   = 2;
   localparam int EV_RECV   = 3;
   localparam int EV_ACK    = 4;

   typedef logic [EV_N-1:0] ev_vec_t;

   typedef enum logic [1:0] {
      PH_HDR  = 2'd0,
      PH_LOW  = 2'd1,
      PH_DATA = 2'd2,
      PH_RHDR = 2'd3
   } tx_phase_e;

   localparam ev_vec_t EVV_START  = ev_vec_t'(1) << EV_START;
   localparam ev_vec_t EVV_RSTART = ev_vec_t'(1) << EV_RSTART;
   localparam ev_vec_t EVV_STOP   = ev_vec_t'(1) << EV_STOP;
   localparam ev_vec_t EVV_RECV   = ev_vec_t'(1) << EV_RECV;
   localparam ev_vec_t EVV_ACK    = ev_vec_t'(1) << EV_ACK;
endpackage

// File: rtl/i2c_seq_hdr.sv
module i2c_seq_hdr #(
   parameter bit TEN_BIT_EN = 1'b1
) (
   input  logic [9:0] addr,
   input  logic       ten_req,
   input  logic       rnw,
   output logic       use_ten,
   output logic [7:0] first_byte,
   output logic [7:0] low_byte,
   output logic [7:0] read_byte
);
   localparam logic [4:0] TEN_MARK = 5'b11110;

   assign low_byte = addr[7:0];

   generate
      if (TEN_BIT_EN) begin : g_ten
         assign use_ten    = ten_req;
         assign first_byte = ten_req ? {TEN_MARK, addr[9:8], 1'b0} : {addr[6:0], rnw};
         assign read_byte  = ten_req ? {TEN_MARK, addr[9:8], 1'b1} : {addr[6:0], 1'b1};
      end else begin : g_seven
         logic unused_hi;
         assign unused_hi  = ^{ten_req, addr[9:7]};
         assign use_ten    = 1'b0;
         assign first_byte = {addr[6:0], rnw};
         assign read_byte  = {addr[6:0], 1'b1};
      end
   endgenerate
endmodule

// File: rtl/i2c_seq_cnt.sv
module i2c_seq_cnt #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         dec,
   output logic         is_zero,
   output logic         is_one
);
   localparam logic [W-1:0] ONE = W'(1);
   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    cnt_q <= '0;
      else if (load)                 cnt_q <= load_val;
      else if (dec && cnt_q != '0)   cnt_q <= cnt_q - ONE;
   end

   assign is_zero = (cnt_q == '0);
   assign is_one  = (cnt_q == ONE);
endmodule

// File: rtl/i2c_msg_seq.sv
module i2c_msg_seq
   import i2c_seq_pkg::*;
#(
   parameter int CNT_W      = 4,
   parameter bit TEN_BIT_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             desc_valid,
   output logic             desc_ready,
   input  logic [9:0]       desc_addr,
   input  logic             desc_ten,
   input  logic             desc_rnw,
   input  logic [CNT_W-1:0] desc_wr_cnt,
   input  logic [CNT_W-1:0] desc_rd_cnt,
   input  logic [7:0]       wr_data,
   output logic             wr_next,
   output logic [4:0]       ev_req,
   output logic             tx_act,
   output logic [7:0]       tx_byte,
   output logic             ack_nack,
   input  logic             ev_done,
   input  logic             ack_in,
   input  logic [7:0]       rx_byte,
   output logic [7:0]       rx_data,
   output logic             rx_valid,
   output logic             done,
   output logic             err
);
   generate
      if (CNT_W < 1 || CNT_W > 16) begin : g_bad_cnt
         $error("CNT_W must lie in 1..16");
      end
   endgenerate

   ev_vec_t    ev_q, ev_d;
   logic       tx_q, tx_d;
   tx_phase_e  ph_q, ph_d;
   logic [7:0] byte_q, byte_d;
   logic       nack_q, nack_d;
   logic [9:0] addr_q;
   logic       ten_q, rnw_q;
   logic       idle, accept;
   logic       wr_dec, rd_dec, wr_nx_d, rxv_d, done_d, err_set;
   logic       wr_zero, wr_one, rd_zero, rd_one;
   logic       use_ten;
   logic [7:0] hdr_first, hdr_low, hdr_read;
   logic       go_low, go_rs, go_rd, go_wr;

   assign idle   = (ev_q == '0) && !tx_q;
   assign accept = desc_valid && idle;

   i2c_seq_hdr #(.TEN_BIT_EN(TEN_BIT_EN)) u_hdr (
      .addr(addr_q), .ten_req(ten_q), .rnw(rnw_q), .use_ten(use_ten),
      .first_byte(hdr_first), .low_byte(hdr_low), .read_byte(hdr_read)
   );

   i2c_seq_cnt #(.W(CNT_W)) u_wr_cnt (
      .clk(clk), .rst_n(rst_n), .load(accept),
      .load_val(desc_rnw ? '0 : desc_wr_cnt), .dec(wr_dec),
      .is_zero(wr_zero), .is_one(wr_one)
   );

   i2c_seq_cnt #(.W(CNT_W)) u_rd_cnt (
      .clk(clk), .rst_n(rst_n), .load(accept), .load_val(desc_rd_cnt),
      .dec(rd_dec), .is_zero(rd_zero), .is_one(rd_one)
   );

   logic unused_cnt;
   assign unused_cnt = wr_one;

   // next-event selection after a successful transmission
   assign go_low = (ph_q == PH_HDR) && use_ten;
   assign go_rs  = (ph_q == PH_LOW) && rnw_q;
   assign go_rd  = ((ph_q == PH_HDR) && !use_ten && rnw_q) || (ph_q == PH_RHDR);
   assign go_wr  = ((ph_q == PH_HDR) && !use_ten && !rnw_q) ||
                   ((ph_q == PH_LOW) && !rnw_q) || (ph_q == PH_DATA);

   always_comb begin
      ev_d    = ev_q;
      tx_d    = tx_q;
      ph_d    = ph_q;
      byte_d  = byte_q;
      nack_d  = nack_q;
      wr_dec  = 1'b0;
      rd_dec  = 1'b0;
      wr_nx_d = 1'b0;
      rxv_d   = 1'b0;
      done_d  = 1'b0;
      err_set = 1'b0;
      if (accept) begin
         ev_d = EVV_START;
         ph_d = PH_HDR;
      end else if (ev_done && !idle) begin
         if (ev_q[EV_START]) begin
            ev_d   = '0;
            tx_d   = 1'b1;
            byte_d = hdr_first;
            ph_d   = PH_HDR;
         end else if (ev_q[EV_RSTART]) begin
            ev_d   = '0;
            tx_d   = 1'b1;
            byte_d = hdr_read;
            ph_d   = PH_RHDR;
         end else if (ev_q[EV_STOP]) begin
            ev_d   = '0;
            done_d = 1'b1;
         end else if (ev_q[EV_RECV]) begin
            ev_d   = EVV_ACK;
            rxv_d  = 1'b1;
            rd_dec = 1'b1;
            nack_d = rd_one;
         end else if (ev_q[EV_ACK]) begin
            ev_d = rd_zero ? EVV_STOP : EVV_RECV;
         end else if (tx_q) begin
            tx_d = 1'b0;
            if (ack_in) begin
               ev_d    = EVV_STOP;
               err_set = 1'b1;
            end else if (go_low) begin
               tx_d   = 1'b1;
               byte_d = hdr_low;
               ph_d   = PH_LOW;
            end else if (go_rs) begin
               ev_d = EVV_RSTART;
            end else if (go_rd) begin
               ev_d = rd_zero ? EVV_STOP : EVV_RECV;
            end else if (go_wr) begin
               if (!wr_zero) begin
                  tx_d    = 1'b1;
                  byte_d  = wr_data;
                  ph_d    = PH_DATA;
                  wr_dec  = 1'b1;
                  wr_nx_d = 1'b1;
               end else begin
                  ev_d = rd_zero ? EVV_STOP : EVV_RSTART;
               end
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ev_q     <= '0;
         tx_q     <= 1'b0;
         ph_q     <= PH_HDR;
         byte_q   <= '0;
         nack_q   <= 1'b0;
         addr_q   <= '0;
         ten_q    <= 1'b0;
         rnw_q    <= 1'b0;
         rx_data  <= '0;
         rx_valid <= 1'b0;
         done     <= 1'b0;
         err      <= 1'b0;
         wr_next  <= 1'b0;
      end else begin
         ev_q     <= ev_d;
         tx_q     <= tx_d;
         ph_q     <= ph_d;
         byte_q   <= byte_d;
         nack_q   <= nack_d;
         rx_valid <= rxv_d;
         done     <= done_d;
         wr_next  <= wr_nx_d;
         if (rxv_d) rx_data <= rx_byte;
         if (accept) begin
            addr_q <= desc_addr;
            ten_q  <= desc_ten;
            rnw_q  <= desc_rnw;
            err    <= 1'b0;
         end else if (err_set) begin
            err    <= 1'b1;
         end
      end
   end

   assign desc_ready = idle;
   assign ev_req     = ev_q;
   assign tx_act     = tx_q;
   assign tx_byte    = byte_q;
   assign ack_nack   = nack_q;
endmodule

// File: rtl/i2c_msg_seq_chk.sv
module i2c_msg_seq_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       desc_valid,
   input logic       desc_ready,
   input logic [4:0] ev_req,
   input logic       tx_act,
   input logic       ev_done,
   input logic       ack_in,
   input logic       rx_valid,
   input logic       done,
   input logic       err
);
   // R2
   one_hot_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ev_req, tx_act}));

   // R2
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((ev_req != 5'd0 || tx_act) && !ev_done) |=> ($stable(ev_req) && $stable(tx_act)));

   // R3
   start_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ev_req[0]) |-> $past(desc_valid && desc_ready));

   // R3
   start_then_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_done && ev_req[0]) |=> tx_act);

   // R8
   rx_then_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |-> ev_req[4]);

   // R9
   nack_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_done && tx_act && ack_in) |=> (ev_req == 5'b00100 && err));

   // R10
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R10
   done_after_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(ev_done && ev_req[2]));
endmodule

bind i2c_msg_seq i2c_msg_seq_chk u_chk (
   .clk(clk), .rst_n(rst_n), .desc_valid(desc_valid), .desc_ready(desc_ready),
   .ev_req(ev_req), .tx_act(tx_act), .ev_done(ev_done), .ack_in(ack_in),
   .rx_valid(rx_valid), .done(done), .err(err)
);

// File: tb/i2c_msg_seq_test.sv
module i2c_msg_seq_test;
   localparam int CLK_P = 10;
   localparam int LAT   = 3;
   localparam int CW    = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          desc_valid = 1'b0;
   logic          desc_ready;
   logic [9:0]    desc_addr = '0;
   logic          desc_ten = 1'b0;
   logic          desc_rnw = 1'b0;
   logic [CW-1:0] desc_wr_cnt = '0;
   logic [CW-1:0] desc_rd_cnt = '0;
   logic [7:0]    wr_data;
   logic          wr_next;
   logic [4:0]    ev_req;
   logic          tx_act;
   logic [7:0]    tx_byte;
   logic          ack_nack;
   logic          ev_done = 1'b0;
   logic          ack_in = 1'b0;
   logic [7:0]    rx_byte = '0;
   logic [7:0]    rx_data;
   logic          rx_valid;
   logic          done;
   logic          err;

   int checks = 0;
   int errors = 0;

   logic [15:0] log_q [0:63];
   logic [15:0] exp_q [0:63];
   logic [7:0]  wmem  [0:15];
   logic [7:0]  rx_got[0:15];
   int log_n = 0, exp_n = 0, tx_seen = 0, rx_seen = 0, rx_n = 0;
   int done_n = 0, nack_at = -1, widx = 0, lat = 0, bad_hot = 0;

   i2c_msg_seq #(.CNT_W(CW)) uut (
      .clk(clk), .rst_n(rst_n), .desc_valid(desc_valid), .desc_ready(desc_ready),
      .desc_addr(desc_addr), .desc_ten(desc_ten), .desc_rnw(desc_rnw),
      .desc_wr_cnt(desc_wr_cnt), .desc_rd_cnt(desc_rd_cnt), .wr_data(wr_data),
      .wr_next(wr_next), .ev_req(ev_req), .tx_act(tx_act), .tx_byte(tx_byte),
      .ack_nack(ack_nack), .ev_done(ev_done), .ack_in(ack_in), .rx_byte(rx_byte),
      .rx_data(rx_data), .rx_valid(rx_valid), .done(done), .err(err)
   );

   always #(CLK_P/2) clk = ~clk;

   assign wr_data = wmem[widx[3:0]];

   // engine model: completes each request LAT cycles after it appears
   always @(posedge clk) begin
      if (!rst_n) begin
         ev_done <= 1'b0;
         lat <= 0;
      end else if (ev_done) begin
         ev_done <= 1'b0;
      end else if (ev_req != 5'd0 || tx_act) begin
         if (lat == LAT - 1) begin
            lat <= 0;
            ev_done <= 1'b1;
            ack_in <= tx_act && (tx_seen == nack_at);
            if (log_n < 64) begin
               if (tx_act)           log_q[log_n] = {8'h06, tx_byte};
               else if (ev_req[0])   log_q[log_n] = 16'h0100;
               else if (ev_req[1])   log_q[log_n] = 16'h0200;
               else if (ev_req[2])   log_q[log_n] = 16'h0300;
               else if (ev_req[3])   log_q[log_n] = 16'h0400;
               else                  log_q[log_n] = {8'h05, 7'd0, ack_nack};
               log_n++;
            end
            if (tx_act) tx_seen++;
            if (ev_req[3]) begin
               rx_byte <= 8'hC3 + 8'(rx_seen * 7);
               rx_seen++;
            end
         end else begin
            lat <= lat + 1;
         end
      end
   end

   always @(posedge clk) if (wr_next) widx <= widx + 1;

   always @(negedge clk) begin
      if (rx_valid && rx_n < 16) begin rx_got[rx_n] = rx_data; rx_n++; end
      if (done) done_n++;
      if (rst_n && $countones({ev_req, tx_act}) > 1) bad_hot++;
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
      end
   endtask

   task automatic push(input logic [15:0] e);
      exp_q[exp_n] = e;
      exp_n++;
   endtask

   task automatic push_tx(input logic [7:0] b, inout int n, input int nk, inout bit ab);
      if (!ab) begin
         push({8'h06, b});
         if (n == nk) begin ab = 1'b1; push(16'h0300); end
         n++;
      end
   endtask

   task automatic build_exp(input logic [9:0] a, input bit ten, input bit rnw,
                            input int wc, input int rc, input int nk);
      int n = 0;
      bit ab = 1'b0;
      bit rd = 1'b0;
      exp_n = 0;
      push(16'h0100);
      if (ten) begin
         push_tx({5'b11110, a[9:8], 1'b0}, n, nk, ab);
         push_tx(a[7:0], n, nk, ab);
      end else begin
         push_tx({a[6:0], rnw}, n, nk, ab);
      end
      if (!rnw) for (int i = 0; i < wc; i++) push_tx(wmem[i], n, nk, ab);
      if (!ab && ((ten && rnw) || (!rnw && rc > 0))) begin
         push(16'h0200);
         push_tx(ten ? {5'b11110, a[9:8], 1'b1} : {a[6:0], 1'b1}, n, nk, ab);
         rd = 1'b1;
      end
      if (!ten && rnw) rd = 1'b1;
      if (!ab && rd)
         for (int i = 0; i < rc; i++) begin
            push(16'h0400);
            push({15'h0280, (i == rc - 1)});
         end
      if (!ab) push(16'h0300);
   endtask

   task automatic run_msg(input logic [9:0] a, input bit ten, input bit rnw,
                          input int wc, input int rc, input int nk, input bit intrude);
      @(negedge clk);
      log_n = 0; tx_seen = 0; rx_seen = 0; rx_n = 0; done_n = 0; nack_at = nk;
      widx <= 0;
      desc_addr = a; desc_ten = ten; desc_rnw = rnw;
      desc_wr_cnt = CW'(wc); desc_rd_cnt = CW'(rc);
      desc_valid = 1'b1;
      @(negedge clk);
      desc_valid = 1'b0;
      if (intrude) begin
         repeat (7) @(negedge clk);
         desc_addr = 10'h033; desc_rnw = 1'b1; desc_rd_cnt = CW'(1);
         desc_valid = 1'b1;
         @(negedge clk);
         desc_valid = 1'b0;
      end
      for (int i = 0; i < 3000 && done_n == 0; i++) @(negedge clk);
      repeat (2) @(negedge clk);
   endtask

   task automatic cmp_log(input string req);
      chk(log_n == exp_n, req, "event count", log_n, exp_n);
      for (int i = 0; i < exp_n && i < log_n; i++)
         chk(log_q[i] == exp_q[i], req, $sformatf("event %0d", i), int'(log_q[i]), int'(exp_q[i]));
   endtask

   task automatic chk_rx(input int rc, input string req);
      chk(rx_n == rc, req, "rx count", rx_n, rc);
      for (int i = 0; i < rc && i < rx_n; i++)
         chk(rx_got[i] == 8'hC3 + 8'(i * 7), req, $sformatf("rx byte %0d", i),
             int'(rx_got[i]), int'(8'hC3 + 8'(i * 7)));
   endtask

   task automatic chk_end(input bit exp_err, input string req);
      chk(done_n == 1, "R10", "done pulses", done_n, 1);
      chk(err == exp_err, req, "err flag", int'(err), int'(exp_err));
      chk(desc_ready == 1'b1, req, "idle after message", int'(desc_ready), 1);
   endtask

   task automatic t_reset;
      chk(ev_req == 5'd0, "R1", "ev_req", int'(ev_req), 0);
      chk(tx_act == 1'b0, "R1", "tx_act", int'(tx_act), 0);
      chk(desc_ready == 1'b1, "R1", "desc_ready", int'(desc_ready), 1);
      chk(done == 1'b0 && err == 1'b0 && rx_valid == 1'b0, "R1", "done/err/rx_valid",
          int'({done, err, rx_valid}), 0);
   endtask

   task automatic t_write7;   // R4 R6
      build_exp(10'h050, 1'b0, 1'b0, 3, 0, -1);
      run_msg(10'h050, 1'b0, 1'b0, 3, 0, -1, 1'b0);
      cmp_log("R6");
      chk(widx == 3, "R6", "wr_next pulses", widx, 3);
      chk_end(1'b0, "R4");
   endtask

   task automatic t_read7;    // R4 R8
      build_exp(10'h02B, 1'b0, 1'b1, 0, 3, -1);
      run_msg(10'h02B, 1'b0, 1'b1, 0, 3, -1, 1'b0);
      cmp_log("R8");
      chk_rx(3, "R8");
      chk_end(1'b0, "R4");
   endtask

   task automatic t_comb7;    // R7
      build_exp(10'h051, 1'b0, 1'b0, 2, 2, -1);
      run_msg(10'h051, 1'b0, 1'b0, 2, 2, -1, 1'b0);
      cmp_log("R7");
      chk_rx(2, "R7");
      chk_end(1'b0, "R7");
   endtask

   task automatic t_write10;  // R5
      build_exp(10'h2A5, 1'b1, 1'b0, 2, 0, -1);
      run_msg(10'h2A5, 1'b1, 1'b0, 2, 0, -1, 1'b0);
      cmp_log("R5");
      chk_end(1'b0, "R5");
   endtask

   task automatic t_read10;   // R5 R8
      build_exp(10'h1C3, 1'b1, 1'b1, 0, 2, -1);
      run_msg(10'h1C3, 1'b1, 1'b1, 0, 2, -1, 1'b0);
      cmp_log("R5");
      chk_rx(2, "R8");
      chk_end(1'b0, "R5");
   endtask

   task automatic t_nack_addr; // R9
      build_exp(10'h044, 1'b0, 1'b0, 2, 1, 0);
      run_msg(10'h044, 1'b0, 1'b0, 2, 1, 0, 1'b0);
      cmp_log("R9");
      chk(rx_n == 0, "R9", "no reception after nack", rx_n, 0);
      chk_end(1'b1, "R9");
   endtask

   task automatic t_nack_data; // R9
      build_exp(10'h3F0, 1'b1, 1'b0, 3, 0, 3);
      run_msg(10'h3F0, 1'b1, 1'b0, 3, 0, 3, 1'b0);
      cmp_log("R9");
      chk_end(1'b1, "R9");
   endtask

   task automatic t_zero;     // R11, also err cleared by next descriptor (R10)
      build_exp(10'h012, 1'b0, 1'b0, 0, 0, -1);
      run_msg(10'h012, 1'b0, 1'b0, 0, 0, -1, 1'b0);
      cmp_log("R11");
      chk_end(1'b0, "R10");
   endtask

   task automatic t_intrude;  // R3
      bit started = 1'b0;
      build_exp(10'h066, 1'b0, 1'b0, 2, 0, -1);
      run_msg(10'h066, 1'b0, 1'b0, 2, 0, -1, 1'b1);
      cmp_log("R3");
      chk_end(1'b0, "R3");
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         if (ev_req != 5'd0 || tx_act) started = 1'b1;
      end
      chk(!started, "R3", "ignored descriptor started later", int'(started), 0);
   endtask

   initial begin
      #(CLK_P * 150000);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      for (int i = 0; i < 16; i++) wmem[i] = 8'h10 + 8'(i * 3);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_write7();
      t_read7();
      t_comb7();
      t_write10();
      t_read10();
      t_nack_addr();
      t_nack_data();
      t_zero();
      t_intrude();
      chk(bad_hot == 0, "R2", "cycles with several state bits", bad_hot, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule